// File: doc/BRIEF.md
# Endpoint Configuration Bank and Packet Memory Allocator

This block holds one configuration word per endpoint for a full-speed USB device controller: an enable flag, a transfer direction and a maximum packet size. A microcontroller writes the sixteen words strictly in index order. The in-order write to the highest index starts allocation on its own. The block then walks the endpoints from index 0 upward, one per clock. It gives every enabled endpoint a contiguous region of a shared packet memory, packed tightly from address 0.

When the walk ends the block pulses `allocDone`. It raises either `configOk` or `configError`, depending on whether the total fits the memory. Firmware uses the result to choose how to answer the host: an empty status packet on the control endpoint, or a stall. Endpoint 0 is the control endpoint. Its settings are fixed, it stays enabled and it is never cleared by either reset. A bus reset, given as a synchronous input, has the same effect as the hardware reset on everything else.

Top module: `epcfg_alloc`

## Requirements
- R1: When `rstN` is low, or `busReset` is high at a clock edge, endpoints 1 to 15 become disabled with direction 0 and size 0. All allocation outputs for them become 0. `allocBusy`, `allocDone`, `configOk`, `configError` and `seqError` become 0, and the next expected index becomes 0.
- R2: Endpoint 0 always reads enabled, with direction 0, size `CTRL_SIZE` and base 0. Values written to index 0 are not stored.
- R3: A write (`cfgWrEn` high, `allocBusy` low, `busReset` low) whose `cfgIndex` equals the next expected index is accepted. It stores `cfgEnable` as the enable, `cfgDirIn` as the direction (1 = IN) and `cfgMaxSize` as the size, and it advances the expected index. These are visible on `epEnabled`/`epDirIn` bit `cfgIndex` after the edge.
- R4: A write with any other index stores nothing, sets `seqError` and sets the expected index back to 0. An accepted write to index 0 clears `seqError`.
- R5: The accepted write to index 15 starts allocation. `allocBusy` is high for exactly 16 cycles starting with the next cycle, and one endpoint is handled per cycle in rising index order.
- R6: Each enabled endpoint's base (slice i of `epBase`) is the sum of the sizes of the enabled endpoints with lower indices, and its size (slice i of `epSize`) is its configured size. A disabled endpoint gets base 0 and size 0.
- R7: `allocDone` is high for exactly one cycle, the first cycle after `allocBusy` falls at the end of a walk.
- R8: In the `allocDone` cycle, `configOk` is high when the total of all allocated sizes is at most `MEM_DEPTH` (an exact fit counts as success), and `configError` is high otherwise. Both are cleared when a walk starts and are never high together.
- R9: Writes made while `allocBusy` is high have no effect. They store nothing, leave `seqError` and the expected index unchanged, and do not change the result.
- R10: A `busReset` during a walk aborts it. `allocBusy` drops after that edge, no `allocDone` follows, and the R1 state results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| busReset | input | 1 | Synchronous bus reset, active high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgIndex | input | 4 | Endpoint index of the write |
| cfgEnable | input | 1 | Enable flag to store |
| cfgDirIn | input | 1 | Direction to store, 1 = IN |
| cfgMaxSize | input | SIZE_W | Maximum packet size to store |
| allocBusy | output | 1 | Allocation walk in progress |
| allocDone | output | 1 | One-cycle pulse at the end of a walk |
| configOk | output | 1 | Last walk fitted the memory |
| configError | output | 1 | Last walk overflowed the memory |
| seqError | output | 1 | An out-of-order write was seen |
| epEnabled | output | 16 | Enable per endpoint |
| epDirIn | output | 16 | Direction per endpoint |
| epBase | output | 16*(SIZE_W+4) | Base address per endpoint, slice i for endpoint i |
| epSize | output | 16*SIZE_W | Allocated size per endpoint, slice i for endpoint i |

## Verification
Two things can meet in one cycle: a register write and an allocation step, or a bus reset and an allocation step. The bench provokes the first case by issuing writes in the middle of a walk. One write goes to index 0, which would be in order if it were accepted, and one enables a disabled endpoint. Both must leave the scoreboard result, `seqError` and the following sequence untouched. The bench provokes the second case by pulsing `busReset` partway through a walk. It then expects the cleared state at once and no done pulse afterwards; any unexpected pulse is caught by the monitor, which finds its queue empty.

// File: rtl/epcfg_pkg.sv
package epcfg_pkg;
  localparam int NUM_EP = 16;
  localparam int IDX_W  = $clog2(NUM_EP);

  typedef logic [IDX_W-1:0] ep_idx_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    clearAll;
    logic    store;
    logic    walkStart;
    logic    walkStep;
    logic    walkLast;
    ep_idx_t walkIdx;
  } ctrl_strobe_t;
endpackage

// File: rtl/epcfg_ctrl.sv
module epcfg_ctrl
  import epcfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busReset,
  input  logic         cfgWrEn,
  input  ep_idx_t      cfgIndex,
  output ctrl_strobe_t strobe,
  output logic         allocBusy,
  output logic         allocDone,
  output logic         seqError
);
  localparam ep_idx_t LAST_IDX = ep_idx_t'(NUM_EP - 1);

  ep_idx_t nextIdx;
  ep_idx_t walkIdx;
  logic    accept;
  logic    inOrder;

  always_comb begin
    accept           = cfgWrEn && !allocBusy && !busReset;
    inOrder          = (cfgIndex == nextIdx);
    strobe.clearAll  = busReset;
    strobe.store     = accept && inOrder;
    strobe.walkStart = accept && inOrder && (nextIdx == LAST_IDX);
    strobe.walkStep  = allocBusy && !busReset;
    strobe.walkLast  = allocBusy && !busReset && (walkIdx == LAST_IDX);
    strobe.walkIdx   = walkIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextIdx   <= '0;
      walkIdx   <= '0;
      allocBusy <= 1'b0;
      allocDone <= 1'b0;
      seqError  <= 1'b0;
    end else if (busReset) begin
      nextIdx   <= '0;
      walkIdx   <= '0;
      allocBusy <= 1'b0;
      allocDone <= 1'b0;
      seqError  <= 1'b0;
    end else begin
      allocDone <= strobe.walkLast;
      if (accept) begin
        if (inOrder) begin
          nextIdx <= (nextIdx == LAST_IDX) ? '0 : nextIdx + 1'b1;
          if (cfgIndex == '0) seqError <= 1'b0;
        end else begin
          seqError <= 1'b1;
          nextIdx  <= '0;
        end
      end
      if (strobe.walkStart) begin
        allocBusy <= 1'b1;
        walkIdx   <= '0;
      end else if (strobe.walkStep) begin
        walkIdx <= walkIdx + 1'b1;
        if (strobe.walkLast) allocBusy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/epcfg_datapath.sv
module epcfg_datapath
  import epcfg_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  parameter int SIZE_W    = 11,
  parameter int CTRL_SIZE = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrl_strobe_t                       strobe,
  input  ep_idx_t                            cfgIndex,
  input  logic                               cfgEnable,
  input  logic                               cfgDirIn,
  input  logic [SIZE_W-1:0]                  cfgMaxSize,
  output logic [NUM_EP-1:0]                  epEnabled,
  output logic [NUM_EP-1:0]                  epDirIn,
  output logic [NUM_EP*(SIZE_W+IDX_W)-1:0]   epBase,
  output logic [NUM_EP*SIZE_W-1:0]           epSize,
  output logic                               configOk,
  output logic                               configError
);
  localparam int SUM_W = SIZE_W + IDX_W;
  localparam logic [SUM_W-1:0]  DEPTH_LIM = SUM_W'(MEM_DEPTH);
  localparam logic [SIZE_W-1:0] CTRL_SZ   = SIZE_W'(CTRL_SIZE);

  logic              cfgEn   [NUM_EP];
  logic              cfgDir  [NUM_EP];
  logic [SIZE_W-1:0] cfgSize [NUM_EP];
  logic [SUM_W-1:0]  baseTab [NUM_EP];
  logic [SIZE_W-1:0] sizeTab [NUM_EP];

  logic [SUM_W-1:0]  acc;
  logic              ovf;
  logic              curEn;
  logic [SIZE_W-1:0] curSize;
  logic [SUM_W-1:0]  sum;
  logic              sumOvf;

  // configuration bank; entry 0 is held at its fixed values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EP; i++) begin
        cfgEn[i]   <= (i == 0);
        cfgDir[i]  <= 1'b0;
        cfgSize[i] <= (i == 0) ? CTRL_SZ : '0;
      end
    end else if (strobe.clearAll) begin
      for (int i = 0; i < NUM_EP; i++) begin
        cfgEn[i]   <= (i == 0);
        cfgDir[i]  <= 1'b0;
        cfgSize[i] <= (i == 0) ? CTRL_SZ : '0;
      end
    end else if (strobe.store && (cfgIndex != '0)) begin
      cfgEn[cfgIndex]   <= cfgEnable;
      cfgDir[cfgIndex]  <= cfgDirIn;
      cfgSize[cfgIndex] <= cfgMaxSize;
    end
  end

  // running-sum allocation, one endpoint per step
  always_comb begin
    curEn   = cfgEn[strobe.walkIdx];
    curSize = curEn ? cfgSize[strobe.walkIdx] : '0;
    sum     = acc + SUM_W'(curSize);
    sumOvf  = ovf || (sum > DEPTH_LIM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EP; i++) begin
        baseTab[i] <= '0;
        sizeTab[i] <= (i == 0) ? CTRL_SZ : '0;
      end
      acc         <= '0;
      ovf         <= 1'b0;
      configOk    <= 1'b0;
      configError <= 1'b0;
    end else if (strobe.clearAll) begin
      for (int i = 0; i < NUM_EP; i++) begin
        baseTab[i] <= '0;
        sizeTab[i] <= (i == 0) ? CTRL_SZ : '0;
      end
      acc         <= '0;
      ovf         <= 1'b0;
      configOk    <= 1'b0;
      configError <= 1'b0;
    end else if (strobe.walkStart) begin
      acc         <= '0;
      ovf         <= 1'b0;
      configOk    <= 1'b0;
      configError <= 1'b0;
    end else if (strobe.walkStep) begin
      baseTab[strobe.walkIdx] <= curEn ? acc : '0;
      sizeTab[strobe.walkIdx] <= curSize;
      acc <= sum;
      ovf <= sumOvf;
      if (strobe.walkLast) begin
        configOk    <= !sumOvf;
        configError <= sumOvf;
      end
    end
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_out
    assign epEnabled[g]                = cfgEn[g];
    assign epDirIn[g]                  = cfgDir[g];
    assign epBase[g*SUM_W +: SUM_W]    = baseTab[g];
    assign epSize[g*SIZE_W +: SIZE_W]  = sizeTab[g];
  end
endmodule

// File: rtl/epcfg_alloc.sv
module epcfg_alloc
  import epcfg_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  parameter int SIZE_W    = 11,
  parameter int CTRL_SIZE = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busReset,
  input  logic                              cfgWrEn,
  input  logic [IDX_W-1:0]                  cfgIndex,
  input  logic                              cfgEnable,
  input  logic                              cfgDirIn,
  input  logic [SIZE_W-1:0]                 cfgMaxSize,
  output logic                              allocBusy,
  output logic                              allocDone,
  output logic                              configOk,
  output logic                              configError,
  output logic                              seqError,
  output logic [NUM_EP-1:0]                 epEnabled,
  output logic [NUM_EP-1:0]                 epDirIn,
  output logic [NUM_EP*(SIZE_W+IDX_W)-1:0]  epBase,
  output logic [NUM_EP*SIZE_W-1:0]          epSize
);
  ctrl_strobe_t strobe;

  epcfg_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busReset  (busReset),
    .cfgWrEn   (cfgWrEn),
    .cfgIndex  (cfgIndex),
    .strobe    (strobe),
    .allocBusy (allocBusy),
    .allocDone (allocDone),
    .seqError  (seqError)
  );

  epcfg_datapath #(
    .MEM_DEPTH (MEM_DEPTH),
    .SIZE_W    (SIZE_W),
    .CTRL_SIZE (CTRL_SIZE)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgIndex    (cfgIndex),
    .cfgEnable   (cfgEnable),
    .cfgDirIn    (cfgDirIn),
    .cfgMaxSize  (cfgMaxSize),
    .epEnabled   (epEnabled),
    .epDirIn     (epDirIn),
    .epBase      (epBase),
    .epSize      (epSize),
    .configOk    (configOk),
    .configError (configError)
  );
endmodule

// File: rtl/epcfg_alloc_chk.sv
module epcfg_alloc_chk
  import epcfg_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  parameter int SIZE_W    = 11,
  parameter int CTRL_SIZE = 64
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              busReset,
  input logic                              allocBusy,
  input logic                              allocDone,
  input logic                              configOk,
  input logic                              configError,
  input logic [NUM_EP-1:0]                 epEnabled,
  input logic [NUM_EP*(SIZE_W+IDX_W)-1:0]  epBase,
  input logic [NUM_EP*SIZE_W-1:0]          epSize
);
  localparam int SUM_W = SIZE_W + IDX_W;

  logic [7:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyCnt <= '0;
    else if (allocBusy) busyCnt <= busyCnt + 1'b1;
    else                busyCnt <= '0;
  end

  assert_bus_reset_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!allocBusy && !allocDone && !configOk && !configError
                  && epEnabled == NUM_EP'(1)));

  assert_ctrl_ep_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    epEnabled[0] && epSize[SIZE_W-1:0] == SIZE_W'(CTRL_SIZE) && epBase[SUM_W-1:0] == '0);

  assert_walk_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |-> busyCnt == 8'(NUM_EP));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |=> !allocDone);

  assert_done_after_walk_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(allocBusy) && !$past(busReset)) |-> allocDone);

  assert_result_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(configOk && configError));

  for (genvar g = 1; g < NUM_EP; g++) begin : g_off
    assert_disabled_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
      (allocDone && !epEnabled[g]) |->
        (epSize[g*SIZE_W +: SIZE_W] == '0 && epBase[g*SUM_W +: SUM_W] == '0));
  end
endmodule

bind epcfg_alloc epcfg_alloc_chk #(
  .MEM_DEPTH (MEM_DEPTH),
  .SIZE_W    (SIZE_W),
  .CTRL_SIZE (CTRL_SIZE)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busReset    (busReset),
  .allocBusy   (allocBusy),
  .allocDone   (allocDone),
  .configOk    (configOk),
  .configError (configError),
  .epEnabled   (epEnabled),
  .epBase      (epBase),
  .epSize      (epSize)
);

// File: tb/test_epcfg_alloc.sv
module test_epcfg_alloc;
  import epcfg_pkg::*;
  localparam int MEM_DEPTH = 1024;
  localparam int SIZE_W    = 11;
  localparam int CTRL_SIZE = 64;
  localparam int SUM_W     = SIZE_W + IDX_W;

  logic clk, rstN, busReset, cfgWrEn, cfgEnable, cfgDirIn;
  logic [IDX_W-1:0] cfgIndex;
  logic [SIZE_W-1:0] cfgMaxSize;
  logic allocBusy, allocDone, configOk, configError, seqError;
  logic [NUM_EP-1:0] epEnabled, epDirIn;
  logic [NUM_EP*SUM_W-1:0] epBase;
  logic [NUM_EP*SIZE_W-1:0] epSize;

  typedef struct packed {
    logic [NUM_EP*SUM_W-1:0]  base;
    logic [NUM_EP*SIZE_W-1:0] size;
    logic                     ok;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   mEn[NUM_EP];
  bit   mDir[NUM_EP];
  int   mSize[NUM_EP];

  epcfg_alloc #(.MEM_DEPTH(MEM_DEPTH), .SIZE_W(SIZE_W), .CTRL_SIZE(CTRL_SIZE)) i_epcfg_alloc (
    .clk(clk), .rstN(rstN), .busReset(busReset), .cfgWrEn(cfgWrEn), .cfgIndex(cfgIndex),
    .cfgEnable(cfgEnable), .cfgDirIn(cfgDirIn), .cfgMaxSize(cfgMaxSize),
    .allocBusy(allocBusy), .allocDone(allocDone), .configOk(configOk),
    .configError(configError), .seqError(seqError), .epEnabled(epEnabled),
    .epDirIn(epDirIn), .epBase(epBase), .epSize(epSize));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(bit good, string req, string what, logic [255:0] act, logic [255:0] expv);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic wr(int idx, bit en, bit dir, int sz);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIndex = ep_idx_t'(idx); cfgEnable = en;
    cfgDirIn = dir; cfgMaxSize = SIZE_W'(sz);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic exp_t model();
    exp_t e; int acc; bit en; int sz;
    e = '0; e.ok = 1'b1; acc = 0;
    for (int i = 0; i < NUM_EP; i++) begin
      en = (i == 0) ? 1'b1 : mEn[i];
      sz = (i == 0) ? CTRL_SIZE : (en ? mSize[i] : 0);
      e.base[i*SUM_W +: SUM_W]   = en ? SUM_W'(acc) : '0;
      e.size[i*SIZE_W +: SIZE_W] = SIZE_W'(sz);
      acc += sz;
      if (acc > MEM_DEPTH) e.ok = 1'b0;
    end
    return e;
  endfunction

  // driver: program all registers, push the expected result, time the walk
  task automatic runAlloc(string tag, bit junk);
    int cnt; logic [NUM_EP-1:0] expEn, expDir;
    for (int i = 0; i < NUM_EP; i++) wr(i, mEn[i], mDir[i], mSize[i]);
    expQ.push_back(model());
    cnt = 0;
    while (allocBusy && cnt < 40) begin
      cnt++;
      if (junk && cnt == 4) begin
        cfgWrEn = 1'b1; cfgIndex = '0; cfgEnable = 1'b0; cfgMaxSize = 11'd3;
      end else if (junk && cnt == 9) begin
        cfgWrEn = 1'b1; cfgIndex = ep_idx_t'(2); cfgEnable = 1'b1; cfgMaxSize = 11'd7;
      end else cfgWrEn = 1'b0;
      @(negedge clk);
    end
    cfgWrEn = 1'b0;
    check(cnt == NUM_EP, "R5", {tag, " busy cycles"}, cnt, NUM_EP);
    check(allocDone == 1'b1, "R7", {tag, " done after busy"}, allocDone, 1);
    for (int i = 0; i < NUM_EP; i++) begin
      expEn[i]  = (i == 0) ? 1'b1 : mEn[i];
      expDir[i] = (i == 0) ? 1'b0 : mDir[i];
    end
    check(epEnabled == expEn, "R3", {tag, " enables"}, epEnabled, expEn);
    check(epDirIn == expDir, "R3", {tag, " directions"}, epDirIn, expDir);
    check(seqError == 1'b0, "R4", {tag, " seqError after ordered run"}, seqError, 0);
    @(negedge clk);
    check(allocDone == 1'b0, "R7", {tag, " done one cycle"}, allocDone, 0);
  endtask

  // monitor: pop one expected item per done pulse
  always @(negedge clk) begin
    if (rstN && allocDone) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(epBase == e.base, "R6", "bases", epBase, e.base);
        check(epSize == e.size, "R6", "sizes", epSize, e.size);
        check(configOk == e.ok, "R8", "configOk", configOk, e.ok);
        check(configError == !e.ok, "R8", "configError", configError, !e.ok);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; busReset = 1'b0; cfgWrEn = 1'b0; cfgIndex = '0;
    cfgEnable = 1'b0; cfgDirIn = 1'b0; cfgMaxSize = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R2 reset state
    check(epEnabled == 16'h0001, "R1", "reset enables", epEnabled, 16'h0001);
    check(epSize == (NUM_EP*SIZE_W)'(CTRL_SIZE), "R2", "reset sizes", epSize, CTRL_SIZE);
    check(epBase == '0, "R1", "reset bases", epBase, 0);
    check({allocBusy, allocDone, configOk, configError, seqError} == '0, "R1", "reset flags",
          {allocBusy, allocDone, configOk, configError, seqError}, 0);

    // R3 / R4 ordering
    wr(0, 1, 0, 64);
    wr(1, 1, 1, 40);
    check(epEnabled[1] && epDirIn[1], "R3", "ep1 stored", {epEnabled[1], epDirIn[1]}, 3);
    check(seqError == 1'b0, "R3", "no error in order", seqError, 0);
    wr(5, 1, 0, 99);
    check(seqError == 1'b1, "R4", "out of order flagged", seqError, 1);
    check(epEnabled[5] == 1'b0, "R4", "out of order not stored", epEnabled[5], 0);
    wr(1, 0, 0, 10);
    check(seqError == 1'b1 && epEnabled[1], "R4", "restart expects index 0",
          {seqError, epEnabled[1]}, 3);
    wr(0, 0, 1, 5);
    check(seqError == 1'b0, "R4", "index 0 clears error", seqError, 0);
    check(epEnabled[0] && !epDirIn[0] && epSize[SIZE_W-1:0] == SIZE_W'(CTRL_SIZE), "R2",
          "ep0 write ignored", {epEnabled[0], epDirIn[0], epSize[SIZE_W-1:0]}, {2'b10, 11'd64});
    wr(3, 1, 0, 8);  // out of order again, back to 0

    // exact fit: sixteen endpoints of 64 fill 1024
    for (int i = 0; i < NUM_EP; i++) begin mEn[i] = 1; mDir[i] = i[0]; mSize[i] = 64; end
    mSize[0] = 9;
    runAlloc("exact fit R8", 1'b0);

    // one word over
    mSize[15] = 65;
    runAlloc("overflow by one R8", 1'b0);

    // odd endpoints only, writes during the walk (R9)
    for (int i = 0; i < NUM_EP; i++) begin mEn[i] = i[0]; mDir[i] = i[0]; mSize[i] = i*8 + 3; end
    runAlloc("sparse with busy writes R9", 1'b1);
    check(epEnabled[2] == 1'b0, "R9", "busy write not stored", epEnabled[2], 0);

    // only the control endpoint
    for (int i = 0; i < NUM_EP; i++) begin mEn[i] = 0; mDir[i] = 0; mSize[i] = 500; end
    runAlloc("ctrl only R6", 1'b0);

    // large endpoint overflows early
    mEn[1] = 1; mSize[1] = 1000; mEn[7] = 1; mSize[7] = 10; mDir[7] = 1;
    runAlloc("early overflow R8", 1'b0);

    // R10 abort by bus reset
    for (int i = 0; i < NUM_EP; i++) begin mEn[i] = 1; mDir[i] = 1; mSize[i] = 16; end
    runAlloc("before abort R6", 1'b0);
    for (int i = 0; i < NUM_EP; i++) wr(i, mEn[i], mDir[i], mSize[i]);
    repeat (5) @(negedge clk);
    busReset = 1'b1;
    @(negedge clk);
    busReset = 1'b0;
    check(allocBusy == 1'b0, "R10", "busy dropped", allocBusy, 0);
    check(epEnabled == 16'h0001 && epDirIn == '0, "R10", "config cleared",
          {epEnabled, epDirIn}, 32'h00010000);
    check(epSize == (NUM_EP*SIZE_W)'(CTRL_SIZE) && epBase == '0, "R10", "tables cleared",
          epSize, CTRL_SIZE);
    check(!configOk && !configError, "R10", "result cleared", {configOk, configError}, 0);
    repeat (25) @(negedge clk);
    check(expQ.size() == 0, "R7", "all results seen", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule